// File: doc/BRIEF.md
# Static RAM Write Strobe Sequencer

This block connects a synchronous host to an external asynchronous static RAM with 8-bit data and 11-bit address. The host offers one write at a time with a valid/ready handshake. For each accepted request the sequencer produces the chip-select, write-enable and output-enable strobes, the address and the data, together with the enable for the shared data-bus driver. Every memory timing value is an integer number of clock cycles set by a parameter: address setup, write pulse, chip-select pulse, data setup, data hold, write recovery and write-to-high-impedance.

Each request also selects the strobe that controls the write. In write-enable control, chip-select falls first and the write-enable pulse forms the write window. In chip-select control, write-enable falls first and the chip-select pulse forms the window. In write-enable control with output enable held low, the memory is driving the bus when the pulse begins. The sequencer therefore keeps its own driver off for the write-to-high-impedance time and lengthens the pulse so that the data setup time still fits inside it. Chip-select control pays no such penalty.

The cycle of the final recovery count doubles as the idle cycle in which the next request is accepted. Back-to-back requests therefore lose no cycles beyond recovery.

Top module: `sram_wr_seq`

## Requirements
- R1: While reset is asserted, and right after it, mem_cs_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0 and req_ready is 1.
- R2: Each accepted request produces exactly one window in which mem_cs_n and mem_we_n are both 0. When the window closes, the memory stores req_data at req_addr, and the last write to an address wins. Without requests there is no window.
- R3: mem_addr does not change while mem_cs_n and mem_we_n are both 0.
- R4: Write-enable control (req_cs_mode=0) with output enable low (req_oe_low=1): the window lasts max(T_WP, T_WHZ+T_DW) cycles. mem_dq_oe stays 0 for the first T_WHZ cycles of the window. The block never drives data while mem_cs_n=0, mem_we_n=1 and mem_oe_n=0.
- R5: Write-enable control with req_oe_low=0: the window lasts T_WP cycles, and mem_oe_n is 1 during the request.
- R6: Chip-select control (req_cs_mode=1): mem_we_n is already 0 and mem_cs_n is 1 in the cycle before the window opens. The window lasts T_CW cycles for either value of req_oe_low.
- R7: Data is driven unchanged for at least T_DW cycles up to the end of the window. It is held for at least T_DH cycles after the window ends. mem_dq_oe falls only when both strobes are 1.
- R8: req_ready is 0 from acceptance until recovery completes. mem_addr changes only on acceptance. A new address appears no earlier than T_WR cycles, and no earlier than T_DH+1 cycles, after the window ends. With req_valid held high, consecutive acceptances are 1+T_AS+L+T_DH+max(T_WR-T_DH-1,0) cycles apart, where L is the window length.
- R9: req_cs_mode and req_oe_low are sampled only at acceptance. Changing them during a request does not alter that request's window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host offers a write |
| req_ready | output | 1 | Block can accept a write this cycle |
| req_addr | input | 11 | Write address |
| req_data | input | 8 | Write data |
| req_cs_mode | input | 1 | 1 = chip-select controlled, 0 = write-enable controlled |
| req_oe_low | input | 1 | 1 = output enable held low during the write |
| mem_addr | output | 11 | Memory address |
| mem_dq_out | output | 8 | Data toward the memory bus |
| mem_dq_oe | output | 1 | Enable of the data-bus driver |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
The hardest situation to reach is the moment when the block's driver could collide with the memory's own outputs. This happens in write-enable control with output enable low, in the window between the fall of write-enable and the end of the high-impedance wait, and again at the hold edge. The table holds requests back to back and alternates the control style and the output-enable setting, so every transition between styles occurs right at the recovery boundary. A behavioural monitor counts undriven window cycles, setup and hold, and flags contention. A directed test flips the style inputs in the middle of a request to show that they are sampled only at acceptance.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ASET,
    ST_STRB,
    ST_HOLD,
    ST_RCVR
  } wr_state_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_wr_len.sv
module sram_wr_len
  import sram_wr_pkg::*;
#(
  parameter int unsigned T_WP  = 3,
  parameter int unsigned T_CW  = 3,
  parameter int unsigned T_DW  = 2,
  parameter int unsigned T_WHZ = 2,
  parameter int unsigned CNT_W = 6
) (
  input  logic             cs_mode,
  input  logic             oe_low,
  output logic [CNT_W-1:0] pulse_len,
  output logic [CNT_W-1:0] drive_at,
  output logic             drive_late
);
  localparam int unsigned LEN_WE_OEL = umax(T_WP, T_WHZ + T_DW);
  localparam int unsigned AT_WE_OEL  = LEN_WE_OEL - T_WHZ;

  always_comb begin
    drive_late = !cs_mode && oe_low;
    drive_at   = CNT_W'(AT_WE_OEL);
    if (cs_mode) begin
      pulse_len = CNT_W'(T_CW);
    end else if (oe_low) begin
      pulse_len = CNT_W'(LEN_WE_OEL);
    end else begin
      pulse_len = CNT_W'(T_WP);
    end
  end
endmodule

// File: rtl/sram_wr_ctr.sv
module sram_wr_ctr #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             zero
);
  logic dec_en;

  assign zero   = (cnt == '0);
  assign dec_en = !load && !zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (dec_en) begin
      cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned T_AS   = 2,
  parameter int unsigned T_WP   = 3,
  parameter int unsigned T_CW   = 3,
  parameter int unsigned T_DW   = 2,
  parameter int unsigned T_DH   = 1,
  parameter int unsigned T_WR   = 3,
  parameter int unsigned T_WHZ  = 2,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_cs_mode,
  input  logic              req_oe_low,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n
);
  localparam int unsigned REC_CYC = (T_WR > T_DH + 1) ? (T_WR - T_DH - 1) : 0;

  wr_state_e        state_q, state_d;
  logic             cs_mode_q, oe_low_q;
  logic             cs_n_d, we_n_d, oe_n_d, dq_oe_d;
  logic             accept;
  logic             ctr_load;
  logic [CNT_W-1:0] ctr_val, cnt;
  logic             cnt_zero;
  logic [CNT_W-1:0] pulse_len, drive_at;
  logic             drive_late;

  sram_wr_len #(
    .T_WP(T_WP), .T_CW(T_CW), .T_DW(T_DW), .T_WHZ(T_WHZ), .CNT_W(CNT_W)
  ) len_i (
    .cs_mode   (cs_mode_q),
    .oe_low    (oe_low_q),
    .pulse_len (pulse_len),
    .drive_at  (drive_at),
    .drive_late(drive_late)
  );

  sram_wr_ctr #(.CNT_W(CNT_W)) ctr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ctr_load),
    .load_val(ctr_val),
    .cnt     (cnt),
    .zero    (cnt_zero)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d  = state_q;
    ctr_load = 1'b0;
    ctr_val  = '0;
    cs_n_d   = mem_cs_n;
    we_n_d   = mem_we_n;
    oe_n_d   = mem_oe_n;
    dq_oe_d  = mem_dq_oe;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d  = ST_ASET;
          ctr_load = 1'b1;
          ctr_val  = CNT_W'(T_AS - 1);
          cs_n_d   = req_cs_mode;
          we_n_d   = !req_cs_mode;
          oe_n_d   = !req_oe_low;
          dq_oe_d  = req_cs_mode || !req_oe_low;
        end
      end
      ST_ASET: begin
        if (cnt_zero) begin
          state_d  = ST_STRB;
          ctr_load = 1'b1;
          ctr_val  = pulse_len - CNT_W'(1);
          cs_n_d   = 1'b0;
          we_n_d   = 1'b0;
        end
      end
      ST_STRB: begin
        if (drive_late && (cnt == drive_at)) begin
          dq_oe_d = 1'b1;
        end
        if (cnt_zero) begin
          state_d  = ST_HOLD;
          ctr_load = 1'b1;
          ctr_val  = CNT_W'(T_DH - 1);
          cs_n_d   = 1'b1;
          if (!cs_mode_q) begin
            we_n_d = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (cnt_zero) begin
          cs_n_d  = 1'b1;
          we_n_d  = 1'b1;
          oe_n_d  = 1'b1;
          dq_oe_d = 1'b0;
          if (REC_CYC > 0) begin
            state_d  = ST_RCVR;
            ctr_load = 1'b1;
            ctr_val  = CNT_W'(REC_CYC - 1);
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_RCVR: begin
        if (cnt_zero) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mem_cs_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      state_q   <= state_d;
      mem_cs_n  <= cs_n_d;
      mem_we_n  <= we_n_d;
      mem_oe_n  <= oe_n_d;
      mem_dq_oe <= dq_oe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      cs_mode_q  <= 1'b0;
      oe_low_q   <= 1'b0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_data;
      cs_mode_q  <= req_cs_mode;
      oe_low_q   <= req_oe_low;
    end
  end

  // R3: address frozen inside the write window
  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !mem_we_n) |=> (mem_cs_n || mem_we_n || $stable(mem_addr)));

  // R4: never drive while the memory may be driving
  p_no_contention_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && !mem_cs_n && mem_we_n) |-> mem_oe_n);

  // R4: late drive starts only after write enable has been low a while
  p_late_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_mode_q && oe_low_q && $rose(mem_dq_oe)) |-> (!mem_we_n && $past(!mem_we_n)));

  // R6: chip select falls after write enable in chip-select control
  p_cs_after_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_cs_n) && cs_mode_q) |-> (!mem_we_n && $past(!mem_we_n)));

  // R7: driver released only with both strobes high
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_dq_oe) |-> (mem_cs_n && mem_we_n));

  // R8: busy after acceptance, address moves only on acceptance
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_addr_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> $past(req_valid && req_ready));
endmodule

// File: tb/sram_wr_seq_tb_top.sv
module sram_wr_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T_AS = 2, T_WP = 3, T_CW = 3, T_DW = 2, T_DH = 1, T_WR = 3, T_WHZ = 2;
  localparam int REC_B = (T_WR > T_DH + 1) ? (T_WR - T_DH - 1) : 0;
  localparam int NV = 6;
  // {cs_mode, oe_low, addr[10:0], data[7:0], expected window length[3:0]}
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 1'b1, 11'h000, 8'hA5, 4'd4},
    {1'b0, 1'b0, 11'h7FF, 8'h3C, 4'd3},
    {1'b1, 1'b1, 11'h155, 8'hC3, 4'd3},
    {1'b1, 1'b0, 11'h2AA, 8'h00, 4'd3},
    {1'b0, 1'b1, 11'h7FF, 8'hFF, 4'd4},
    {1'b0, 1'b0, 11'h001, 8'h81, 4'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [10:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic req_cs_mode = 1'b0, req_oe_low = 1'b0;
  logic [10:0] mem_addr;
  logic [7:0]  mem_dq_out;
  logic mem_dq_oe, mem_cs_n, mem_we_n, mem_oe_n;

  int checks = 0, failures = 0, cyc = 0;
  int windows = 0, requests = 0, addr_viol = 0, contention = 0;
  bit acc_mode = 0, acc_oel = 0;
  int acc_cyc = 0;
  logic [7:0] shadow [2048];
  logic [7:0] refm [2048];

  sram_wr_seq #(
    .T_AS(T_AS), .T_WP(T_WP), .T_CW(T_CW), .T_DW(T_DW),
    .T_DH(T_DH), .T_WR(T_WR), .T_WHZ(T_WHZ)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_cs_mode(req_cs_mode),
    .req_oe_low(req_oe_low), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_len(input bit m, input bit o);
    if (m) return T_CW;
    if (o) return (T_WP > T_WHZ + T_DW) ? T_WP : T_WHZ + T_DW;
    return T_WP;
  endfunction

  // behavioural memory monitor
  bit prev_ov = 0, prev_oe = 0, prev_cs_n = 1, prev_we_n = 1, in_hold = 0, ov_dq = 0;
  logic [10:0] prev_addr = '0, ov_addr = '0;
  logic [7:0] prev_dq = '0, ov_data = '0;
  int ovlen = 0, dstab = 0, last_dstab = 0, undriven = 0, hold_cnt = 0, since_end = 100;

  always @(negedge clk) begin
    bit ov;
    ov = rst_n && !mem_cs_n && !mem_we_n;
    if (mem_dq_oe) dstab = (prev_oe && mem_dq_out == prev_dq) ? dstab + 1 : 1;
    else dstab = 0;
    if (mem_dq_oe && !mem_cs_n && mem_we_n && !mem_oe_n) contention++;
    if (ov && !prev_ov && acc_mode)
      chk(!prev_we_n && prev_cs_n, "R6 we low before cs falls", prev_we_n, 0);
    if (ov) begin
      if (prev_ov && mem_addr != prev_addr) addr_viol++;
      ovlen++;
      if (!mem_dq_oe && ovlen == undriven + 1) undriven++;
      last_dstab = dstab;
      ov_addr = mem_addr; ov_data = mem_dq_out; ov_dq = mem_dq_oe;
    end
    if (prev_ov && !ov) begin
      windows++;
      chk(ovlen == exp_len(acc_mode, acc_oel), "R4/R5/R6/R9 window length", ovlen,
          exp_len(acc_mode, acc_oel));
      chk(ov_dq && last_dstab >= T_DW, "R7 data setup", last_dstab, T_DW);
      chk(undriven == ((!acc_mode && acc_oel) ? T_WHZ : 0), "R4 undriven window cycles",
          undriven, (!acc_mode && acc_oel) ? T_WHZ : 0);
      shadow[ov_addr] = ov_data;
      in_hold = 1; hold_cnt = 0; since_end = 0;
      ovlen = 0; undriven = 0;
    end
    if (in_hold) begin
      if (mem_dq_oe && mem_dq_out == ov_data) hold_cnt++;
      else begin
        chk(hold_cnt >= T_DH, "R7 data hold", hold_cnt, T_DH);
        in_hold = 0;
      end
    end
    if (!ov && rst_n && mem_addr != prev_addr && windows > 0)
      chk(since_end >= T_WR && since_end >= T_DH + 1, "R8 address gap after window",
          since_end, T_WR);
    if (!ov) since_end++;
    prev_ov = ov; prev_oe = mem_dq_oe; prev_dq = mem_dq_out; prev_addr = mem_addr;
    prev_cs_n = mem_cs_n; prev_we_n = mem_we_n;
  end

  // caller is at a negedge; returns at the negedge after acceptance
  task automatic send(input bit m, input bit o, input logic [10:0] a, input logic [7:0] d);
    req_valid = 1; req_cs_mode = m; req_oe_low = o; req_addr = a; req_data = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    acc_mode = m; acc_oel = o; acc_cyc = cyc; requests++;
    refm[a] = d;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int prev_acc;
    int prev_len;
    for (int i = 0; i < 2048; i++) begin shadow[i] = 'x; refm[i] = 'x; end
    #(CLK_PERIOD * 2 + 1);
    chk(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes high in reset",
        {mem_cs_n, mem_we_n, mem_oe_n}, 7);
    chk(!mem_dq_oe && req_ready, "R1 driver off and ready in reset", {mem_dq_oe, req_ready}, 1);
    @(negedge clk); rst_n = 1;
    repeat (5) @(negedge clk);
    chk(mem_cs_n && mem_we_n && !mem_dq_oe && req_ready, "R1 idle after reset",
        {mem_cs_n, mem_we_n, mem_dq_oe, req_ready}, 13);
    chk(windows == 0, "R2 no window without request", windows, 0);

    // back-to-back table walk
    prev_acc = 0; prev_len = 0;
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][24], VEC[i][23], VEC[i][22:12], VEC[i][11:4]);
      if (i == 0) chk(!req_ready, "R8 ready low after acceptance", req_ready, 0);
      if (i > 0)
        chk(acc_cyc - prev_acc == 1 + T_AS + prev_len + T_DH + REC_B,
            "R8 back-to-back period", acc_cyc - prev_acc, 1 + T_AS + prev_len + T_DH + REC_B);
      chk(int'(VEC[i][3:0]) == exp_len(VEC[i][24], VEC[i][23]), "R4/R5/R6 table length",
          VEC[i][3:0], exp_len(VEC[i][24], VEC[i][23]));
      prev_acc = acc_cyc; prev_len = VEC[i][3:0];
    end
    req_valid = 0;
    repeat (20) @(negedge clk);

    // R9: style inputs flipped while busy
    send(1'b0, 1'b1, 11'h444, 8'h5A);
    req_valid = 0; req_cs_mode = 1; req_oe_low = 0;
    chk(!mem_oe_n, "R9 output enable from sampled setting", mem_oe_n, 0);
    repeat (20) @(negedge clk);

    // R5: output enable stays high in write-enable control without oe_low
    send(1'b0, 1'b0, 11'h010, 8'h77);
    req_valid = 0;
    chk(mem_oe_n && !mem_cs_n, "R5 oe high during request", {mem_oe_n, mem_cs_n}, 2);
    repeat (20) @(negedge clk);

    chk(windows == requests, "R2 one window per request", windows, requests);
    chk(addr_viol == 0, "R3 address stable in window", addr_viol, 0);
    chk(contention == 0, "R4 no bus contention", contention, 0);
    for (int i = 0; i < NV; i++)
      chk(shadow[VEC[i][22:12]] === refm[VEC[i][22:12]], "R2 stored data",
          shadow[VEC[i][22:12]], refm[VEC[i][22:12]]);
    chk(shadow[11'h444] === 8'h5A, "R2 R9 stored data", shadow[11'h444], 8'h5A);
    summary();
  end
endmodule